// File: doc/BRIEF.md
# Interleaved Bit-Serial Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder for a (255,223) code over GF(2^8) with 32 check symbols per codeword. Message bytes enter over a valid/ready byte port and leave on a one-bit-per-clock output, most significant bit first, so the block is its own serialiser. While each byte is being shifted out, the check symbols of its codeword are updated. The product of the feedback symbol and the generator coefficients is built one feedback bit per clock from fixed XOR constants, so no parallel field multiplier exists and the codeblock is never buffered.

Up to five codewords can be interleaved. The interleave depth is sampled with the first byte of a block. Successive message bytes go round-robin to one parity register lane per codeword. Once the last message byte has been accepted, the parity is drained from the lanes without feedback, interleaved in the same round-robin order, and the lanes are left cleared for the next block.

Top module: `rs_bitser_encoder`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: in_ready_o is high only when no block is draining parity and the output shifter is empty or on its last bit. During parity it is low on every bit, except the last bit of the block's final parity symbol.
- R3: A byte accepted on a clock edge (in_valid_i and in_ready_o both high) appears on out_bit_o in the next 8 cycles, bit 7 first, with out_valid_o high and out_par_o low.
- R4: depth_i is sampled only with the first byte of a block. The value 0 selects depth 1, values above 5 select depth 5, and a block then carries 223 times the depth in message bytes.
- R5: After the last message bit, 32 times the depth parity symbols follow with no gap and with out_par_o high.
- R6: Codeword k is made of message bytes k, k+I, k+2I, and so on. Its parity is the remainder of m(x)·x^32 divided by g(x) = product of (x + α^i) for i = 0..31, with field polynomial x^8+x^7+x^2+x+1 and α = 0x02, where byte bit b is the coefficient of α^b. Parity is sent highest degree first, and each degree position is sent for codewords 0..I-1 before the next position.
- R7: A new block may start on the last parity bit of the previous block. Its output does not depend on any earlier block.
- R8: Idle cycles between message bytes do not change the codeword. out_valid_o is low while no byte is being shifted.
- R9: Once a symbol starts, out_valid_o stays high for exactly 8 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| depth_i | input | 3 | Interleave depth request, sampled with the first byte of a block |
| in_valid_i | input | 1 | A message byte is offered |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Encoder takes the offered byte on this edge |
| out_valid_o | output | 1 | out_bit_o carries a code bit |
| out_bit_o | output | 1 | Serial code bit, MSB of each symbol first |
| out_par_o | output | 1 | Current bit belongs to a parity symbol |

## Verification
Two things can happen in the same cycle. On the last bit of one symbol, the next symbol is loaded into the shifter. On that same edge, the lane register bank is written: a message byte is folded into its lane, or a parity symbol is drained from it. At depth 1 this load also reads the lane whose last feedback bit was added one edge earlier. The bench provokes this by offering the next byte at every boundary, across every depth from 1 to 5 and across back-to-back blocks. It judges the result by comparing every emitted symbol and its parity flag with a byte-parallel reference encoder. Separate runs insert idle gaps between bytes and change depth_i in the middle of a block, to show that neither alters the codewords.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MSG  = 2'd1,
        ST_PAR  = 2'd2
    } enc_state_e;

    typedef enum logic [1:0] {
        LOP_HOLD  = 2'd0,
        LOP_FEED  = 2'd1,
        LOP_ACC   = 2'd2,
        LOP_DRAIN = 2'd3
    } lane_op_e;

    // GF(2^8) product, field polynomial given by its low eight bits
    function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b, logic [7:0] poly_lo);
        logic [7:0] r;
        logic [7:0] s;
        r = '0;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ s;
            s = s[7] ? ((s << 1) ^ poly_lo) : (s << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rs_lane_update.sv
module rs_lane_update
    import rs_pkg::*;
#(
    parameter int         NPAR    = 32,
    parameter logic [7:0] POLY_LO = 8'h87,
    parameter int         FCR     = 0
) (
    input  logic [NPAR-1:0][7:0] lane_i,
    input  lane_op_e             op_i,
    input  logic [7:0]           fb_i,
    input  logic [2:0]           bidx_i,
    output logic [NPAR-1:0][7:0] lane_o
);

    // Generator coefficients of degree 0..NPAR-1 (leading one implied)
    function automatic logic [NPAR-1:0][7:0] gen_coeffs();
        logic [7:0] g [0:NPAR];
        logic [7:0] root;
        logic [NPAR-1:0][7:0] res;
        for (int k = 0; k <= NPAR; k++) g[k] = '0;
        g[0] = 8'h01;
        root = 8'h01;
        for (int i = 0; i < FCR; i++) root = gf_mul(root, 8'h02, POLY_LO);
        for (int i = 0; i < NPAR; i++) begin
            for (int k = i + 1; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(g[k], root, POLY_LO);
            g[0] = gf_mul(g[0], root, POLY_LO);
            root = gf_mul(root, 8'h02, POLY_LO);
        end
        for (int k = 0; k < NPAR; k++) res[k] = g[k];
        return res;
    endfunction

    // Each coefficient pre-scaled by alpha^b: feedback bit b selects row b
    function automatic logic [NPAR-1:0][7:0][7:0] scaled_tab();
        logic [NPAR-1:0][7:0]      gc;
        logic [NPAR-1:0][7:0][7:0] t;
        logic [7:0]                v;
        gc = gen_coeffs();
        for (int j = 0; j < NPAR; j++) begin
            v = gc[j];
            for (int b = 0; b < 8; b++) begin
                t[j][b] = v;
                v = v[7] ? ((v << 1) ^ POLY_LO) : (v << 1);
            end
        end
        return t;
    endfunction

    localparam logic [NPAR-1:0][7:0][7:0] GTAB = scaled_tab();

    for (genvar j = 0; j < NPAR; j++) begin : g_tap
        logic [7:0] below;
        if (j == 0) begin : g_bottom
            assign below = '0;
        end else begin : g_upper
            assign below = lane_i[j-1];
        end

        always_comb begin
            unique case (op_i)
                LOP_FEED:  lane_o[j] = below ^ (fb_i[0] ? GTAB[j][0] : 8'h00);
                LOP_ACC:   lane_o[j] = lane_i[j] ^ (fb_i[bidx_i] ? GTAB[j][bidx_i] : 8'h00);
                LOP_DRAIN: lane_o[j] = below;
                default:   lane_o[j] = lane_i[j];
            endcase
        end
    end

endmodule

// File: rtl/rs_serializer.sv
module rs_serializer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] data_i,
    input  logic       par_i,
    output logic       bit_o,
    output logic       valid_o,
    output logic       par_o,
    output logic [2:0] phase_o,
    output logic       ending_o
);

    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] phase;
        logic       valid;
        logic       par;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sh    = data_i;
            s_d.phase = '0;
            s_d.valid = 1'b1;
            s_d.par   = par_i;
        end else if (s_q.valid) begin
            if (s_q.phase == 3'd7) begin
                s_d.valid = 1'b0;
                s_d.par   = 1'b0;
            end else begin
                s_d.sh    = {s_q.sh[6:0], 1'b0};
                s_d.phase = s_q.phase + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o    = s_q.sh[7];
    assign valid_o  = s_q.valid;
    assign par_o    = s_q.par & s_q.valid;
    assign phase_o  = s_q.phase;
    assign ending_o = s_q.valid && (s_q.phase == 3'd7);

endmodule

// File: rtl/rs_bitser_encoder.sv
module rs_bitser_encoder
    import rs_pkg::*;
#(
    parameter int         NMSG    = 223,
    parameter int         NPAR    = 32,
    parameter int         IMAX    = 5,
    parameter logic [7:0] POLY_LO = 8'h87,
    parameter int         FCR     = 0,
    localparam int        DIW     = $clog2(IMAX + 1),
    localparam int        LW      = (IMAX > 1) ? $clog2(IMAX) : 1,
    localparam int        SW      = $clog2(NMSG * IMAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIW-1:0] depth_i,
    input  logic           in_valid_i,
    input  logic [7:0]     in_data_i,
    output logic           in_ready_o,
    output logic           out_valid_o,
    output logic           out_bit_o,
    output logic           out_par_o
);

    typedef struct packed {
        enc_state_e                     state;
        logic [DIW-1:0]                 depth;
        logic [LW-1:0]                  lane;
        logic [LW-1:0]                  acc_lane;
        logic                           acc;
        logic [SW-1:0]                  sym;
        logic [7:0]                     f;
        logic [IMAX-1:0][NPAR-1:0][7:0] bank;
    } st_t;

    st_t st_d, st_q;

    logic [IMAX-1:0][NPAR-1:0][7:0] lane_nxt;
    lane_op_e                       ops [IMAX];
    logic [7:0]                     fb;
    logic [2:0]                     bidx;
    logic                           ser_load, ser_par;
    logic [7:0]                     ser_data;
    logic                           ser_valid, ser_ending;
    logic [2:0]                     ser_phase;
    logic                           slot, take, lane_wrap;
    logic [DIW-1:0]                 eff;
    logic [SW-1:0]                  msg_last, par_last;
    logic [LW-1:0]                  lane_inc;
    logic [7:0]                     top_sym;

    logic                           is_idle;
    logic [IMAX*NPAR*8-1:0]         bank_flat;

    function automatic logic [DIW-1:0] clamp_depth(logic [DIW-1:0] d);
        if (d == '0)                return DIW'(1);
        else if (int'(d) > IMAX)    return DIW'(IMAX);
        else                        return d;
    endfunction

    for (genvar l = 0; l < IMAX; l++) begin : g_lane
        rs_lane_update #(
            .NPAR    (NPAR),
            .POLY_LO (POLY_LO),
            .FCR     (FCR)
        ) u_lane (
            .lane_i (st_q.bank[l]),
            .op_i   (ops[l]),
            .fb_i   (fb),
            .bidx_i (bidx),
            .lane_o (lane_nxt[l])
        );
    end

    rs_serializer u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ser_load),
        .data_i   (ser_data),
        .par_i    (ser_par),
        .bit_o    (out_bit_o),
        .valid_o  (ser_valid),
        .par_o    (out_par_o),
        .phase_o  (ser_phase),
        .ending_o (ser_ending)
    );

    always_comb begin
        st_d       = st_q;
        slot       = !ser_valid || ser_ending;
        in_ready_o = slot && (st_q.state != ST_PAR);
        take       = in_valid_i && in_ready_o;
        eff        = (st_q.state == ST_IDLE) ? clamp_depth(depth_i) : st_q.depth;
        msg_last   = SW'(NMSG * int'(eff)) - SW'(1);
        par_last   = SW'(NPAR * int'(eff)) - SW'(1);
        lane_wrap  = (int'(st_q.lane) + 1) >= int'(eff);
        lane_inc   = lane_wrap ? '0 : st_q.lane + LW'(1);
        top_sym    = st_q.bank[st_q.lane][NPAR-1];
        fb         = st_q.f;
        bidx       = ser_phase + 3'd1;
        ser_load   = 1'b0;
        ser_data   = in_data_i;
        ser_par    = 1'b0;
        for (int l = 0; l < IMAX; l++) ops[l] = LOP_HOLD;

        // remaining feedback bits of the symbol now on the wire
        if (st_q.acc && ser_valid && !ser_ending) ops[st_q.acc_lane] = LOP_ACC;
        if (ser_ending) st_d.acc = 1'b0;

        if (take) begin
            fb              = in_data_i ^ top_sym;
            st_d.f          = fb;
            ops[st_q.lane]  = LOP_FEED;
            ser_load        = 1'b1;
            st_d.acc        = 1'b1;
            st_d.acc_lane   = st_q.lane;
            st_d.lane       = lane_inc;
            if (st_q.state == ST_IDLE) begin
                st_d.depth = eff;
                st_d.sym   = SW'(1);
                st_d.state = ST_MSG;
                if (msg_last == '0) begin
                    st_d.state = ST_PAR;
                    st_d.sym   = '0;
                end
            end else if (st_q.sym == msg_last) begin
                st_d.state = ST_PAR;
                st_d.sym   = '0;
            end else begin
                st_d.sym   = st_q.sym + SW'(1);
            end
        end else if (st_q.state == ST_PAR && slot) begin
            ser_data       = top_sym;
            ser_par        = 1'b1;
            ser_load       = 1'b1;
            ops[st_q.lane] = LOP_DRAIN;
            st_d.lane      = lane_inc;
            if (st_q.sym == par_last) begin
                st_d.state = ST_IDLE;
                st_d.sym   = '0;
                st_d.lane  = '0;
            end else begin
                st_d.sym   = st_q.sym + SW'(1);
            end
        end

        for (int l = 0; l < IMAX; l++) st_d.bank[l] = lane_nxt[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = ser_valid;
    assign is_idle     = (st_q.state == ST_IDLE);
    assign bank_flat   = st_q.bank;

endmodule

// File: rtl/rs_bitser_encoder_chk.sv
module rs_bitser_encoder_chk #(
    parameter int NPAR = 32,
    parameter int IMAX = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid_i,
    input logic [7:0]             in_data_i,
    input logic                   in_ready_o,
    input logic                   out_valid_o,
    input logic                   out_bit_o,
    input logic                   out_par_o,
    input logic [2:0]             ser_phase,
    input logic                   is_idle,
    input logic [IMAX*NPAR*8-1:0] bank_flat
);

    // R2: a byte is only taken when the shifter is free or finishing
    a_r2_ready_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (!out_valid_o || ser_phase == 3'd7));

    // R3: accepted byte starts on the wire next cycle, MSB first, as message
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (out_valid_o && !out_par_o && ser_phase == 3'd0
                                        && out_bit_o == $past(in_data_i[7])));

    // R5: parity starts only directly after a message bit
    a_r5_parity_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_par_o) |-> ($past(out_valid_o) && out_valid_o));

    // R9: eight consecutive bits per symbol
    a_r9_bit_cadence: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && ser_phase != 3'd7) |=> (out_valid_o && ser_phase == $past(ser_phase) + 3'd1));

    // R7: the lanes are left cleared whenever no block is open
    a_r7_idle_clean: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |-> (bank_flat == '0));

    // R2: no byte is taken in the middle of parity
    a_r2_no_take_in_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (out_par_o && ser_phase != 3'd7) |-> !in_ready_o);

endmodule

bind rs_bitser_encoder rs_bitser_encoder_chk #(.NPAR(NPAR), .IMAX(IMAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o),
    .out_par_o   (out_par_o),
    .ser_phase   (ser_phase),
    .is_idle     (is_idle),
    .bank_flat   (bank_flat)
);

// File: tb/rs_bitser_encoder_bench.sv
module rs_bitser_encoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NMSG = 223;
    localparam int NPAR = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] depth_i = 3'd1;
    logic       in_valid_i = 1'b0;
    logic [7:0] in_data_i = 8'h00;
    logic       in_ready_o, out_valid_o, out_bit_o, out_par_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rs_bitser_encoder u_rs_bitser_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .depth_i     (depth_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .out_bit_o   (out_bit_o),
        .out_par_o   (out_par_o)
    );

    // reference arithmetic, byte-parallel
    function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= a;
            a = a[7] ? ((a << 1) ^ 8'h87) : (a << 1);
        end
        return r;
    endfunction

    logic [7:0] gp [0:NPAR];
    logic [7:0] par [0:4][0:NPAR-1];
    logic [9:0] expq [$];   // {last, parity flag, byte}

    function automatic logic [7:0] pbyte(int pat, int idx);
        case (pat)
            0:       return idx[7:0];
            1:       return 8'hFF;
            2:       return 8'h00;
            default: return 8'((idx * 167 + 29) ^ (idx >> 5) ^ pat);
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // output monitor
    logic [7:0] sh_acc = 8'h00;
    int         nb = 0;
    logic       par_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid_o) begin
                logic [9:0] e;
                logic [7:0] got;
                got = {sh_acc[6:0], out_bit_o};
                if (nb == 0) par_seen = out_par_o;
                else if (out_par_o != par_seen) check(1'b0, "R5 flag steady", out_par_o, par_seen);
                if (out_par_o && in_ready_o) begin
                    bit legal;
                    legal = (nb == 7) && (expq.size() > 0) && expq[0][9];
                    check(legal, "R2 ready during parity", nb, 7);
                end
                sh_acc = got;
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    if (expq.size() == 0) begin
                        check(1'b0, "R3 unexpected symbol", got, 0);
                    end else begin
                        e = expq.pop_front();
                        check(par_seen == e[8], "R5 parity flag", par_seen, e[8]);
                        if (e[8]) check(got == e[7:0], "R6 parity symbol", got, e[7:0]);
                        else      check(got == e[7:0], "R3 message passthrough", got, e[7:0]);
                        if (e[9]) check(in_ready_o == 1'b1, "R7 ready at block end", in_ready_o, 1);
                    end
                end
            end else if (nb != 0) begin
                check(1'b0, "R9 symbol cut short", nb, 8);
                nb = 0;
            end
        end
    end

    task automatic send(logic [7:0] b);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = b;
        while (!in_ready_o) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic run_block(int dsel, int pat, bit gaps, bit wiggle);
        int d;
        logic [7:0] m, f;
        d = (dsel == 0) ? 1 : (dsel > 5 ? 5 : dsel);   // R4 clamp
        for (int l = 0; l < 5; l++)
            for (int j = 0; j < NPAR; j++) par[l][j] = 8'h00;
        for (int i = 0; i < NMSG * d; i++) begin
            int l;
            l = i % d;
            m = pbyte(pat, i);
            f = m ^ par[l][NPAR-1];
            for (int j = NPAR - 1; j >= 1; j--) par[l][j] = par[l][j-1] ^ gmul(f, gp[j]);
            par[l][0] = gmul(f, gp[0]);
            expq.push_back({2'b00, m});
        end
        for (int j = NPAR - 1; j >= 0; j--)
            for (int l = 0; l < d; l++)
                expq.push_back({(j == 0 && l == d - 1), 1'b1, par[l][j]});
        depth_i = 3'(dsel);
        for (int i = 0; i < NMSG * d; i++) begin
            send(pbyte(pat, i));
            if (i == 0 && wiggle) depth_i = 3'(dsel + 3);   // R4: ignored mid-block
            if (gaps && (i % 50 == 7)) begin
                @(negedge clk);
                in_valid_i = 1'b0;
                repeat (8) @(negedge clk);
                check(out_valid_o == 1'b0, "R8 idle during gap", out_valid_o, 0);
            end
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // generator roots alpha^0..alpha^31
        logic [7:0] r;
        for (int k = 0; k <= NPAR; k++) gp[k] = 8'h00;
        gp[0] = 8'h01;
        r = 8'h01;
        for (int i = 0; i < NPAR; i++) begin
            for (int k = i + 1; k >= 1; k--) gp[k] = gp[k-1] ^ gmul(gp[k], r);
            gp[0] = gmul(gp[0], r);
            r = gmul(r, 8'h02);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid_o == 1'b0, "R1 reset out_valid", out_valid_o, 0);
        check(in_ready_o == 1'b1, "R1 reset in_ready", in_ready_o, 1);
        rst_n = 1'b1;
        @(negedge clk);

        run_block(1, 0, 1'b0, 1'b0);
        run_block(2, 3, 1'b1, 1'b1);   // R8 gaps, R4 mid-block change
        run_block(3, 1, 1'b0, 1'b0);
        run_block(5, 3, 1'b0, 1'b0);
        run_block(0, 3, 1'b1, 1'b0);   // R4: 0 means depth 1
        run_block(7, 2, 1'b0, 1'b1);   // R4: above 5 means depth 5
        run_block(4, 3, 1'b1, 1'b0);
        run_block(6, 0, 1'b0, 1'b0);   // R7 back-to-back

        @(negedge clk);
        in_valid_i = 1'b0;
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0, "R7 idle after last block", out_valid_o, 0);
        check(in_ready_o == 1'b1, "R7 ready after last block", in_ready_o, 1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule